// File: doc/BRIEF.md
# Multi-Mode Antenna-Carrier Receive Buffer

This block holds the sample stream of one antenna-carrier channel on its way from the link clock domain to the application clock domain. Samples enter on the link side with a marker that flags the first sample of a radio frame. They are stored in a dual-clock buffer whose read and write pointers cross between the domains as Gray code through synchronizer chains.

A two-bit mode input selects how the read side behaves:
- In plain FIFO mode the application pops samples with a read request.
- Synchronous buffer mode works the same way, but a resync pulse returns the read pointer to slot zero so that the application can realign to a known position.
- In self-timed mode the block drains the buffer by itself, one sample per cycle. It raises a start marker alongside the valid strobe on the sample that opens a radio frame.

Sticky overflow and underflow flags and the channel enable are reported on a 3-bit status vector.

Top module: `axc_rx_buffer`

## Requirements
- R1: In FIFO mode (mode 2'b00) and in synchronous buffer mode (mode 2'b01), a read request on a non-empty buffer returns the oldest stored sample on rd_data with rd_valid high one app_clk cycle later. Samples leave in the order they were written.
- R2: In synchronous buffer mode, a resync pulse sampled on app_clk returns the read pointer to slot zero. The next read returns the sample that was stored in slot zero.
- R3: In FIFO mode, the resync input has no effect. The next read returns the next unread sample.
- R4: In self-timed mode (mode 2'b10), the block pops one sample per app_clk cycle whenever the buffer is not empty, and rd_en is ignored. rd_start is high together with rd_valid exactly on samples that were written with wr_sof high.
- R5: rd_start stays low in every mode other than self-timed mode, whatever wr_sof was.
- R6: A write attempted while the buffer holds DEPTH samples is dropped, and it sets the overflow flag, status bit 2.
- R7: A read request while the buffer is empty leaves rd_valid low and keeps rd_data at the last sample delivered. It sets the underflow flag, status bit 1.
- R8: The overflow and underflow flags are sticky. A clr_flags pulse clears both of them on the next app_clk edge.
- R9: Status bit 0 equals chan_en.
- R10: While chan_en is low, writes are not stored, no read takes place, and rd_valid stays low.
- R11: After reset the buffer is empty, rd_valid and rd_start are low, and both flags are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| lnk_clk | input | 1 | Link-side clock |
| lnk_rst_n | input | 1 | Link-side asynchronous reset, active low |
| wr_en | input | 1 | Write request for one sample |
| wr_data | input | DW | Sample to store |
| wr_sof | input | 1 | Marks this sample as the first of a radio frame |
| app_clk | input | 1 | Application-side clock |
| app_rst_n | input | 1 | Application-side asynchronous reset, active low |
| mode | input | 2 | 00 FIFO, 01 synchronous buffer, 10 self-timed, 11 treated as FIFO |
| chan_en | input | 1 | Channel active |
| rd_en | input | 1 | Read request (FIFO and synchronous buffer modes) |
| resync | input | 1 | Read pointer realign pulse (synchronous buffer mode) |
| clr_flags | input | 1 | Clears both sticky flags |
| rd_data | output | DW | Delivered sample |
| rd_valid | output | 1 | rd_data carries a new sample this cycle |
| rd_start | output | 1 | Frame-start marker in self-timed mode |
| status | output | 3 | {overflow, underflow, chan_en} |

## Verification
The bench targets the following corner cases, and what a faulty design would do in each:

- **Write one past full.** A buffer that overwrites instead of dropping returns the ninth sample in place of the first, or shows no overflow flag.
- **Read one past empty.** A design that pops anyway outputs stale data with valid high, or loses the held sample.
- **Same resync, two modes.** A resync pulse is applied in synchronous buffer mode and again in FIFO mode. A design that decodes the mode wrongly either replays slot zero in FIFO mode or continues past it in synchronous buffer mode.
- **Frame markers.** In self-timed mode the start marker must sit on the exact sample that carried it, with no extra pulse. In the other modes the marker must stay silent.
- **Disabled channel.** Writes made while the channel is disabled must leave nothing behind once the channel is enabled again.

// File: rtl/axc_buf_pkg.sv
package axc_buf_pkg;

   typedef enum logic [1:0] {
      MODE_FIFO = 2'b00,
      MODE_SYNC = 2'b01,
      MODE_SELF = 2'b10,
      MODE_RSVD = 2'b11
   } buf_mode_e;

   localparam int ST_OVF = 2;
   localparam int ST_UDF = 1;
   localparam int ST_EN  = 0;
   localparam int ST_W   = 3;

endpackage

// File: rtl/axc_bit_sync.sv
module axc_bit_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("axc_bit_sync: STAGES must be at least 2");
      end
      if (W < 1) begin : g_bad_width
         $error("axc_bit_sync: W must be positive");
      end
   endgenerate

   logic [W-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) chain[i] <= '0;
      end else begin
         chain[0] <= d;
         for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/axc_buf_mem.sv
module axc_buf_mem #(
   parameter int EW    = 17,
   parameter int DEPTH = 8,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          wclk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [EW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [EW-1:0] rdata
);
   generate
      if ((1 << AW) != DEPTH) begin : g_bad_depth
         $error("axc_buf_mem: DEPTH must be a power of two");
      end
   endgenerate

   logic [EW-1:0] cells [DEPTH];

   always_ff @(posedge wclk) begin
      if (we) cells[waddr] <= wdata;
   end

   assign rdata = cells[raddr];
endmodule

// File: rtl/axc_buf_wr.sv
module axc_buf_wr #(
   parameter int DEPTH = 8,
   localparam int AW   = $clog2(DEPTH),
   localparam int PW   = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic          en_s,
   input  logic [PW-1:0] rd_gray_s,
   output logic [PW-1:0] wr_bin,
   output logic [PW-1:0] wr_gray,
   output logic          mem_we,
   output logic          full,
   output logic          ovf_tgl
);
   logic [PW-1:0] rd_bin_s;
   logic [PW-1:0] occ;
   logic [PW-1:0] nxt;
   logic          drop;

   always_comb begin
      rd_bin_s[PW-1] = rd_gray_s[PW-1];
      for (int i = PW - 2; i >= 0; i--) rd_bin_s[i] = rd_bin_s[i+1] ^ rd_gray_s[i];
   end

   assign occ    = wr_bin - rd_bin_s;
   assign full   = (occ >= PW'(DEPTH));
   assign mem_we = wr_en & en_s & ~full;
   assign drop   = wr_en & en_s & full;
   assign nxt    = wr_bin + PW'(mem_we);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_bin  <= '0;
         wr_gray <= '0;
         ovf_tgl <= 1'b0;
      end else begin
         wr_bin  <= nxt;
         wr_gray <= nxt ^ (nxt >> 1);
         if (drop) ovf_tgl <= ~ovf_tgl;
      end
   end
endmodule

// File: rtl/axc_buf_rd.sv
module axc_buf_rd
   import axc_buf_pkg::*;
#(
   parameter int DW    = 16,
   parameter int DEPTH = 8,
   localparam int AW   = $clog2(DEPTH),
   localparam int PW   = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [1:0]    mode,
   input  logic          chan_en,
   input  logic          rd_en,
   input  logic          resync,
   input  logic          clr_flags,
   input  logic [PW-1:0] wr_gray_s,
   input  logic          ovf_tgl_s,
   input  logic [DW-1:0] mem_data,
   input  logic          mem_sof,
   output logic [PW-1:0] rd_bin,
   output logic [PW-1:0] rd_gray,
   output logic          empty,
   output logic [DW-1:0] rd_data,
   output logic          rd_valid,
   output logic          rd_start,
   output logic          ovf_flag,
   output logic          udf_flag
);
   buf_mode_e     mode_e;
   logic [PW-1:0] wr_bin_s;
   logic [PW-1:0] nxt;
   logic          self_timed;
   logic          pop;
   logic          udf_evt;
   logic          ovf_seen;
   logic          ovf_evt;
   logic          realign;

   assign mode_e = buf_mode_e'(mode);

   always_comb begin
      wr_bin_s[PW-1] = wr_gray_s[PW-1];
      for (int i = PW - 2; i >= 0; i--) wr_bin_s[i] = wr_bin_s[i+1] ^ wr_gray_s[i];
   end

   assign empty      = (wr_bin_s == rd_bin);
   assign self_timed = (mode_e == MODE_SELF);
   assign pop        = chan_en & ~empty & (self_timed | rd_en);
   assign udf_evt    = chan_en & ~self_timed & rd_en & empty;
   assign realign    = resync & (mode_e == MODE_SYNC);
   assign nxt        = realign ? '0 : rd_bin + PW'(pop);
   assign ovf_evt    = ovf_tgl_s ^ ovf_seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_bin   <= '0;
         rd_gray  <= '0;
         rd_data  <= '0;
         rd_valid <= 1'b0;
         rd_start <= 1'b0;
         ovf_seen <= 1'b0;
         ovf_flag <= 1'b0;
         udf_flag <= 1'b0;
      end else begin
         rd_bin   <= nxt;
         rd_gray  <= nxt ^ (nxt >> 1);
         rd_valid <= pop;
         rd_start <= pop & self_timed & mem_sof;
         if (pop) rd_data <= mem_data;
         ovf_seen <= ovf_tgl_s;
         if (clr_flags) begin
            ovf_flag <= 1'b0;
            udf_flag <= 1'b0;
         end else begin
            if (ovf_evt) ovf_flag <= 1'b1;
            if (udf_evt) udf_flag <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/axc_rx_buffer.sv
module axc_rx_buffer
   import axc_buf_pkg::*;
#(
   parameter int DW          = 16,
   parameter int DEPTH       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic            lnk_clk,
   input  logic            lnk_rst_n,
   input  logic            wr_en,
   input  logic [DW-1:0]   wr_data,
   input  logic            wr_sof,
   input  logic            app_clk,
   input  logic            app_rst_n,
   input  logic [1:0]      mode,
   input  logic            chan_en,
   input  logic            rd_en,
   input  logic            resync,
   input  logic            clr_flags,
   output logic [DW-1:0]   rd_data,
   output logic            rd_valid,
   output logic            rd_start,
   output logic [ST_W-1:0] status
);
   localparam int AW = $clog2(DEPTH);
   localparam int PW = AW + 1;
   localparam int EW = DW + 1;

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("axc_rx_buffer: DEPTH must be at least 2");
      end
      if (DW < 1) begin : g_bad_dw
         $error("axc_rx_buffer: DW must be positive");
      end
   endgenerate

   logic [PW-1:0] wr_ptr;
   logic [PW-1:0] wr_gray;
   logic [PW-1:0] wr_gray_s;
   logic [PW-1:0] rd_ptr;
   logic [PW-1:0] rd_gray;
   logic [PW-1:0] rd_gray_s;
   logic          en_lnk;
   logic          wr_full;
   logic          mem_we;
   logic          ovf_tgl;
   logic          ovf_tgl_s;
   logic          rd_empty;
   logic          ovf_flag;
   logic          udf_flag;
   logic [EW-1:0] mem_q;

   axc_bit_sync #(.W(1), .STAGES(SYNC_STAGES)) u_en_sync (
      .clk(lnk_clk), .rst_n(lnk_rst_n), .d(chan_en), .q(en_lnk));

   axc_bit_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_rptr_sync (
      .clk(lnk_clk), .rst_n(lnk_rst_n), .d(rd_gray), .q(rd_gray_s));

   axc_bit_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_wptr_sync (
      .clk(app_clk), .rst_n(app_rst_n), .d(wr_gray), .q(wr_gray_s));

   axc_bit_sync #(.W(1), .STAGES(SYNC_STAGES)) u_ovf_sync (
      .clk(app_clk), .rst_n(app_rst_n), .d(ovf_tgl), .q(ovf_tgl_s));

   axc_buf_wr #(.DEPTH(DEPTH)) u_wr (
      .clk       (lnk_clk),
      .rst_n     (lnk_rst_n),
      .wr_en     (wr_en),
      .en_s      (en_lnk),
      .rd_gray_s (rd_gray_s),
      .wr_bin    (wr_ptr),
      .wr_gray   (wr_gray),
      .mem_we    (mem_we),
      .full      (wr_full),
      .ovf_tgl   (ovf_tgl)
   );

   axc_buf_mem #(.EW(EW), .DEPTH(DEPTH)) u_mem (
      .wclk  (lnk_clk),
      .we    (mem_we),
      .waddr (wr_ptr[AW-1:0]),
      .wdata ({wr_sof, wr_data}),
      .raddr (rd_ptr[AW-1:0]),
      .rdata (mem_q)
   );

   axc_buf_rd #(.DW(DW), .DEPTH(DEPTH)) u_rd (
      .clk       (app_clk),
      .rst_n     (app_rst_n),
      .mode      (mode),
      .chan_en   (chan_en),
      .rd_en     (rd_en),
      .resync    (resync),
      .clr_flags (clr_flags),
      .wr_gray_s (wr_gray_s),
      .ovf_tgl_s (ovf_tgl_s),
      .mem_data  (mem_q[DW-1:0]),
      .mem_sof   (mem_q[DW]),
      .rd_bin    (rd_ptr),
      .rd_gray   (rd_gray),
      .empty     (rd_empty),
      .rd_data   (rd_data),
      .rd_valid  (rd_valid),
      .rd_start  (rd_start),
      .ovf_flag  (ovf_flag),
      .udf_flag  (udf_flag)
   );

   always_comb begin
      status         = '0;
      status[ST_OVF] = ovf_flag;
      status[ST_UDF] = udf_flag;
      status[ST_EN]  = chan_en;
   end
endmodule

// File: rtl/axc_rx_buffer_chk.sv
module axc_rx_buffer_chk #(
   parameter int DW = 16,
   parameter int PW = 4
) (
   input logic          app_clk,
   input logic          app_rst_n,
   input logic          lnk_clk,
   input logic          lnk_rst_n,
   input logic [1:0]    mode,
   input logic          chan_en,
   input logic          rd_en,
   input logic          clr_flags,
   input logic [DW-1:0] rd_data,
   input logic          rd_valid,
   input logic          rd_start,
   input logic [2:0]    status,
   input logic          rd_empty,
   input logic          wr_en,
   input logic          wr_full,
   input logic [PW-1:0] wr_ptr
);
   p_start_has_valid_r4: assert property (@(posedge app_clk) disable iff (!app_rst_n)
      rd_start |-> rd_valid);

   p_start_quiet_r5: assert property (@(posedge app_clk) disable iff (!app_rst_n)
      (mode != 2'b10) |=> !rd_start);

   p_drop_full_r6: assert property (@(posedge lnk_clk) disable iff (!lnk_rst_n)
      (wr_en && wr_full) |=> $stable(wr_ptr));

   p_empty_read_r7: assert property (@(posedge app_clk) disable iff (!app_rst_n)
      (rd_en && chan_en && mode != 2'b10 && rd_empty && !clr_flags) |=> (!rd_valid && status[1]));

   p_hold_data_r7: assert property (@(posedge app_clk) disable iff (!app_rst_n)
      !rd_valid |-> $stable(rd_data));

   p_ovf_sticky_r8: assert property (@(posedge app_clk) disable iff (!app_rst_n)
      (status[2] && !clr_flags) |=> status[2]);

   p_udf_sticky_r8: assert property (@(posedge app_clk) disable iff (!app_rst_n)
      (status[1] && !clr_flags) |=> status[1]);

   p_clear_r8: assert property (@(posedge app_clk) disable iff (!app_rst_n)
      clr_flags |=> (status[2:1] == 2'b00));

   p_disabled_quiet_r10: assert property (@(posedge app_clk) disable iff (!app_rst_n)
      !chan_en |=> !rd_valid);
endmodule

bind axc_rx_buffer axc_rx_buffer_chk #(.DW(DW), .PW(PW)) u_chk (
   .app_clk   (app_clk),
   .app_rst_n (app_rst_n),
   .lnk_clk   (lnk_clk),
   .lnk_rst_n (lnk_rst_n),
   .mode      (mode),
   .chan_en   (chan_en),
   .rd_en     (rd_en),
   .clr_flags (clr_flags),
   .rd_data   (rd_data),
   .rd_valid  (rd_valid),
   .rd_start  (rd_start),
   .status    (status),
   .rd_empty  (rd_empty),
   .wr_en     (wr_en),
   .wr_full   (wr_full),
   .wr_ptr    (wr_ptr)
);

// File: tb/sim_axc_rx_buffer.sv
module sim_axc_rx_buffer;
   localparam int DW    = 16;
   localparam int DEPTH = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic          wr_sof = 1'b0;
   logic [1:0]    mode = 2'b00;
   logic          chan_en = 1'b1;
   logic          rd_en = 1'b0;
   logic          resync = 1'b0;
   logic          clr_flags = 1'b0;
   logic [DW-1:0] rd_data;
   logic          rd_valid;
   logic          rd_start;
   logic [2:0]    status;

   int checks = 0;
   int fails  = 0;
   logic [DW-1:0] model_q[$];
   logic [DW-1:0] last_out = '0;

   always #4 clk = ~clk;

   axc_rx_buffer #(.DW(DW), .DEPTH(DEPTH), .SYNC_STAGES(2)) u0 (
      .lnk_clk(clk), .lnk_rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_sof(wr_sof),
      .app_clk(clk), .app_rst_n(rst_n), .mode(mode), .chan_en(chan_en), .rd_en(rd_en),
      .resync(resync), .clr_flags(clr_flags), .rd_data(rd_data), .rd_valid(rd_valid),
      .rd_start(rd_start), .status(status));

   function automatic logic [2:0] exp_status(input bit ovf, input bit udf, input bit en);
      return {ovf, udf, en};
   endfunction

   function automatic logic [DW-1:0] tag_sample(input int base, input int idx);
      return DW'(base * 16 + idx * 3 + 1);
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr1(input logic [DW-1:0] d, input bit sof);
      @(negedge clk);
      wr_en = 1'b1; wr_data = d; wr_sof = sof;
      @(negedge clk);
      wr_en = 1'b0; wr_sof = 1'b0;
   endtask

   task automatic rd1(output logic v, output logic [DW-1:0] d, output logic st);
      @(negedge clk);
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      v = rd_valid; d = rd_data; st = rd_start;
   endtask

   task automatic pulse_clr();
      @(negedge clk); clr_flags = 1'b1;
      @(negedge clk); clr_flags = 1'b0;
   endtask

   task automatic pulse_resync();
      @(negedge clk); resync = 1'b1;
      @(negedge clk); resync = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0;
      idle(3);
      rst_n = 1'b1;
      idle(4);
      model_q.delete();
      last_out = '0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      logic v, st;
      logic [DW-1:0] d;
      void'($urandom(32'd20240611));
      do_reset();

      // R11 / R9: reset state
      check("R11 status after reset", 32'(status), 32'(exp_status(0, 0, 1)));
      check("R11 rd_valid after reset", 32'(rd_valid), 0);
      check("R11 rd_start after reset", 32'(rd_start), 0);

      // R1 / R5: random traffic in FIFO and synchronous buffer modes
      for (int r = 0; r < 30; r++) begin
         int n;
         mode = (r % 2 == 0) ? 2'b00 : 2'b01;
         n = 1 + int'($urandom % DEPTH);
         for (int k = 0; k < n; k++) begin
            logic [DW-1:0] s;
            s = DW'($urandom);
            model_q.push_back(s);
            wr1(s, bit'($urandom % 2));
         end
         idle(6);
         for (int k = 0; k < n; k++) begin
            logic [DW-1:0] e;
            if ($urandom % 2 == 1) idle(1);
            e = model_q.pop_front();
            rd1(v, d, st);
            check("R1 valid on read", 32'(v), 1);
            check("R1 data order", 32'(d), 32'(e));
            check("R5 start low outside self-timed", 32'(st), 0);
            last_out = e;
         end
      end
      check("R6/R7 no flags after balanced traffic", 32'(status), 32'(exp_status(0, 0, 1)));

      // R7 / R8: underflow
      mode = 2'b00;
      idle(6);
      rd1(v, d, st);
      check("R7 empty read valid low", 32'(v), 0);
      check("R7 empty read holds data", 32'(d), 32'(last_out));
      check("R7 underflow flag", 32'(status), 32'(exp_status(0, 1, 1)));
      idle(5);
      check("R8 underflow sticky", 32'(status), 32'(exp_status(0, 1, 1)));
      pulse_clr();
      check("R8 clear", 32'(status), 32'(exp_status(0, 0, 1)));

      // R6: overflow, extra write dropped
      for (int k = 0; k <= DEPTH; k++) begin
         if (k < DEPTH) model_q.push_back(tag_sample(5, k));
         wr1(tag_sample(5, k), 1'b0);
      end
      idle(10);
      check("R6 overflow flag", 32'(status), 32'(exp_status(1, 0, 1)));
      for (int k = 0; k < DEPTH; k++) begin
         logic [DW-1:0] e;
         e = model_q.pop_front();
         rd1(v, d, st);
         check("R6 kept data after overflow", 32'(d), 32'(e));
      end
      idle(6);
      rd1(v, d, st);
      check("R6 dropped sample not stored", 32'(v), 0);
      check("R8 both flags sticky", 32'(status), 32'(exp_status(1, 1, 1)));
      pulse_clr();
      check("R8 clear both", 32'(status), 32'(exp_status(0, 0, 1)));

      // R2: resync in synchronous buffer mode
      do_reset();
      mode = 2'b01;
      for (int k = 0; k < 4; k++) wr1(tag_sample(7, k), 1'b0);
      idle(6);
      rd1(v, d, st); check("R2 first read", 32'(d), 32'(tag_sample(7, 0)));
      rd1(v, d, st); check("R2 second read", 32'(d), 32'(tag_sample(7, 1)));
      pulse_resync();
      idle(4);
      rd1(v, d, st);
      check("R2 resync valid", 32'(v), 1);
      check("R2 resync rereads slot zero", 32'(d), 32'(tag_sample(7, 0)));

      // R3: resync ignored in FIFO mode
      do_reset();
      mode = 2'b00;
      for (int k = 0; k < 4; k++) wr1(tag_sample(9, k), 1'b0);
      idle(6);
      rd1(v, d, st);
      rd1(v, d, st);
      pulse_resync();
      idle(4);
      rd1(v, d, st);
      check("R3 resync ignored", 32'(d), 32'(tag_sample(9, 2)));

      // R4: self-timed mode with frame marker on the third sample
      do_reset();
      mode = 2'b10;
      begin
         int nval, nstart, idx;
         logic [DW-1:0] start_d;
         bit order_ok;
         nval = 0; nstart = 0; idx = 0; start_d = '0; order_ok = 1'b1;
         fork
            begin
               for (int k = 0; k < 5; k++) begin
                  @(negedge clk);
                  wr_en = 1'b1; wr_data = tag_sample(11, k); wr_sof = (k == 2);
               end
               @(negedge clk);
               wr_en = 1'b0; wr_sof = 1'b0;
            end
            begin
               for (int c = 0; c < 25; c++) begin
                  @(negedge clk);
                  if (rd_valid) begin
                     if (rd_data !== tag_sample(11, idx)) order_ok = 1'b0;
                     idx++;
                     nval++;
                  end
                  if (rd_start) begin
                     nstart++;
                     start_d = rd_data;
                  end
               end
            end
         join
         check("R4 self-timed delivered count", 32'(nval), 5);
         check("R4 self-timed order", 32'(order_ok), 1);
         check("R4 one start pulse", 32'(nstart), 1);
         check("R4 start on marked sample", 32'(start_d), 32'(tag_sample(11, 2)));
      end
      rd1(v, d, st);
      check("R4 rd_en ignored when drained", 32'(v), 0);
      check("R4 no underflow from rd_en", 32'(status), 32'(exp_status(0, 0, 1)));

      // R9 / R10: disabled channel
      do_reset();
      mode = 2'b00;
      @(negedge clk); chan_en = 1'b0;
      @(negedge clk);
      check("R9 enable bit low", 32'(status), 32'(exp_status(0, 0, 0)));
      idle(4);
      for (int k = 0; k < 3; k++) wr1(tag_sample(13, k), 1'b0);
      idle(6);
      rd1(v, d, st);
      check("R10 no valid while disabled", 32'(v), 0);
      check("R10 no read attempt while disabled", 32'(status), 32'(exp_status(0, 0, 0)));
      @(negedge clk); chan_en = 1'b1;
      idle(5);
      check("R9 enable bit high", 32'(status), 32'(exp_status(0, 0, 1)));
      rd1(v, d, st);
      check("R10 writes while disabled not stored", 32'(v), 0);
      check("R10 empty after disabled writes", 32'(status), 32'(exp_status(0, 1, 1)));

      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule